// File: doc/BRIEF.md
# ATA Task-File Register Interface

This block is the device side of a parallel ATA disk's register window, as a host sees it over an I/O bus. The host programs a sector count, a 24-bit block address held in three byte registers, and a device-select byte. It then writes an opcode to the command register. It follows progress through the status byte and the primary interrupt line.

Three command families are sequenced:
- **IDENTIFY** is a PIO-in transfer. The host reads 256 words from the data port.
- **Cache flush** is a non-data command. Its completion time is set by a storage backend through a request/done handshake.
- **DMA read/write** is handed to a separate bus-master engine. The handoff carries the block address and count, and is closed by a done pulse from that engine.

Both outgoing requests (flush and DMA) use valid/ready handshakes. Once valid is raised, it and the direction stay steady until ready is seen, so the backend may stall for any number of cycles. The `*_done` pulses carry no back-pressure. The I/O bus side has none either: an access always completes in its cycle.

Top module: `ata_taskfile`

## Requirements
- R1: After reset the status byte reads 0x40, the interrupt is low, no request is valid, and the count, address and device registers read 0.
- R2: Registers answer only at addresses BASE+0 to BASE+7 (BASE = 0x01F0). The offsets are:
  - 0 data
  - 1 error
  - 2 sector count
  - 3, 4, 5 address bytes
  - 6 device
  - 7 status on read, command on write

  Accesses outside the window change nothing and read 0.
- R3: The address bytes at offsets 3, 4 and 5 read back as written and form bits 7:0, 15:8 and 23:16 of `xfer_lba`. The count byte reads back and drives `xfer_count`.
- R4: Opcode 0xEC (IDENTIFY) shows status 0xC0 for PREP_CYCLES cycles, then raises the interrupt and shows 0x48 before each of 256 data-port reads. After the 256th read the status byte is 0x40.
- R5: IDENTIFY word i equals 0x0020 when i = 85 (bit 5, write cache enabled). Every other word is {0xA5, i[7:0]}.
- R6: Opcode 0xE7 (flush) holds `flush_valid` until `flush_ready` and shows status 0xC0 (busy, ready; DRQ, fault and error clear) until a `flush_done` pulse. It then shows 0x40 and raises the interrupt.
- R7: Opcodes 0xC8 and 0xCA raise `dma_valid` with `dma_dir` equal to 1 and 0 respectively. They show 0xC0 until `dma_done`, then show 0x40 and raise the interrupt.
- R8: A status-register read lowers the interrupt. A completion in the same cycle wins.
- R9: While busy (status bit 7 set), command writes and task-file writes are ignored.
- R10: An unsupported opcode completes at once with status 0x41, error register 0x04 and the interrupt raised. The next accepted command clears the error.
- R11: The device register reads back as written. A command written while its bit 4 differs from DEV_ID (0) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| io_addr | input | 16 | host I/O address |
| io_wr | input | 1 | host write strobe |
| io_rd | input | 1 | host read strobe (read side effects) |
| io_wdata | input | 16 | host write data |
| io_rdata | output | 16 | read data, combinational from address |
| irq | output | 1 | primary interrupt line |
| flush_valid | output | 1 | flush request to backend |
| flush_ready | input | 1 | backend accepts flush |
| flush_done | input | 1 | flush complete pulse |
| dma_valid | output | 1 | DMA request to bus master |
| dma_ready | input | 1 | bus master accepts request |
| dma_dir | output | 1 | 1 = device to memory, 0 = memory to device |
| dma_done | input | 1 | DMA complete pulse |
| xfer_lba | output | 24 | programmed block address |
| xfer_count | output | 8 | programmed sector count |

## Verification
The register window is walked with a table of in-window writes, an out-of-window write and reads from both sides of the window. This separates correct decode from aliasing.

IDENTIFY is read out in full, with the status byte checked before every word. That catches an early or late DRQ drop and a wrong word order.

A flush is held pending while busy-time writes and a second opcode are thrown at it. This shows that gating, not timing luck, keeps the address and the request lines unchanged.

Both DMA directions, an unsupported opcode, and a command sent to the other device complete the pattern set. Each of these differs from the others only in the direction bit, the error flag, or the absence of any effect.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DF   = 5;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  localparam logic [7:0] OP_IDENT = 8'hEC;
  localparam logic [7:0] OP_FLUSH = 8'hE7;
  localparam logic [7:0] OP_RDDMA = 8'hC8;
  localparam logic [7:0] OP_WRDMA = 8'hCA;

  typedef enum logic [2:0] {
    OFS_DATA = 3'd0, OFS_ERR = 3'd1, OFS_CNT = 3'd2, OFS_LBA0 = 3'd3,
    OFS_LBA1 = 3'd4, OFS_LBA2 = 3'd5, OFS_DEV = 3'd6, OFS_CMD = 3'd7
  } ofs_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ID_PREP, S_ID_XFER, S_FL_REQ, S_FL_WAIT, S_DMA_REQ, S_DMA_RUN
  } seq_state_t;

  // identify content: word 85 flags write cache on, others carry their index
  function automatic logic [15:0] id_word(input logic [15:0] idx);
    if (idx == 16'd85) return 16'h0020;
    return {8'hA5, idx[7:0]};
  endfunction
endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
#(
  parameter logic [15:0] BASE      = 16'h01F0,
  parameter int          LBA_BYTES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            io_addr,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic [15:0]            io_wdata,
  output logic [15:0]            io_rdata,
  input  logic                   busy,
  input  logic                   drq,
  input  logic [7:0]             status,
  input  logic [7:0]             err_reg,
  input  logic [15:0]            data_word,
  output logic                   cmd_wr,
  output logic [7:0]             cmd_op,
  output logic                   stat_rd,
  output logic                   data_rd,
  output logic                   dev_sel,
  output logic [8*LBA_BYTES-1:0] lba,
  output logic [7:0]             count,
  output logic [7:0]             dev_reg
);
  logic       hit;
  ofs_t       ofs;
  logic       tf_we;
  logic [7:0] lba_q [LBA_BYTES];
  logic [7:0] cnt_q, dev_q;

  assign hit   = (io_addr[15:3] == BASE[15:3]);
  assign ofs   = ofs_t'(io_addr[2:0]);
  assign tf_we = io_wr && hit && !busy;

  assign cmd_wr  = io_wr && hit && (ofs == OFS_CMD);
  assign cmd_op  = io_wdata[7:0];
  assign stat_rd = io_rd && hit && (ofs == OFS_CMD);
  assign data_rd = io_rd && hit && (ofs == OFS_DATA);

  genvar g;
  generate
    for (g = 0; g < LBA_BYTES; g++) begin : g_lba
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          lba_q[g] <= 8'h00;
        else if (tf_we && (io_addr[2:0] == 3'(int'(OFS_LBA0) + g)))
          lba_q[g] <= io_wdata[7:0];
      end
      assign lba[8*g +: 8] = lba_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 8'h00;
      dev_q <= 8'h00;
    end else if (tf_we) begin
      if (ofs == OFS_CNT) cnt_q <= io_wdata[7:0];
      if (ofs == OFS_DEV) dev_q <= io_wdata[7:0];
    end
  end

  assign count   = cnt_q;
  assign dev_reg = dev_q;
  assign dev_sel = dev_q[4];

  always_comb begin
    io_rdata = 16'h0000;
    if (hit) begin
      case (ofs)
        OFS_DATA: io_rdata = drq ? data_word : 16'h0000;
        OFS_ERR:  io_rdata = {8'h00, err_reg};
        OFS_CNT:  io_rdata = {8'h00, cnt_q};
        OFS_DEV:  io_rdata = {8'h00, dev_q};
        OFS_CMD:  io_rdata = {8'h00, status};
        default: begin
          for (int i = 0; i < LBA_BYTES; i++)
            if (io_addr[2:0] == 3'(int'(OFS_LBA0) + i))
              io_rdata = {8'h00, lba_q[i]};
        end
      endcase
    end
  end
endmodule

// File: rtl/ata_tf_idgen.sv
module ata_tf_idgen
  import ata_tf_pkg::*;
#(
  parameter int WORDS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        advance,
  output logic [15:0] word,
  output logic        last
);
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (start)   idx <= '0;
    else if (advance) idx <= idx + 1'b1;
  end

  assign word = id_word(16'(idx));
  assign last = (idx == IW'(WORDS - 1));
endmodule

// File: rtl/ata_tf_seq.sv
module ata_tf_seq
  import ata_tf_pkg::*;
#(
  parameter int   PREP_CYCLES = 4,
  parameter logic DEV_ID      = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_op,
  input  logic       dev_sel,
  input  logic       stat_rd,
  input  logic       data_rd,
  input  logic       id_last,
  input  logic       flush_ready,
  input  logic       flush_done,
  input  logic       dma_ready,
  input  logic       dma_done,
  output logic       busy,
  output logic       drq,
  output logic [7:0] status,
  output logic [7:0] err_reg,
  output logic       irq,
  output logic       id_start,
  output logic       id_adv,
  output logic       flush_valid,
  output logic       dma_valid,
  output logic       dma_dir
);
  localparam int PW = $clog2(PREP_CYCLES + 1);

  seq_state_t     st, st_nx;
  logic [PW-1:0]  prep_cnt;
  logic           err_q, irq_q, dir_q;
  logic           cmd_ok, known, done_evt;

  assign busy   = (st != S_IDLE) && (st != S_ID_XFER);
  assign drq    = (st == S_ID_XFER);
  assign cmd_ok = cmd_wr && !busy && (dev_sel == DEV_ID);
  assign known  = (cmd_op == OP_IDENT) || (cmd_op == OP_FLUSH) ||
                  (cmd_op == OP_RDDMA) || (cmd_op == OP_WRDMA);

  assign id_start = cmd_ok && (cmd_op == OP_IDENT);
  assign id_adv   = drq && data_rd;

  always_comb begin
    st_nx    = st;
    done_evt = 1'b0;
    if (cmd_ok) begin
      case (cmd_op)
        OP_IDENT:          st_nx = S_ID_PREP;
        OP_FLUSH:          st_nx = S_FL_REQ;
        OP_RDDMA, OP_WRDMA: st_nx = S_DMA_REQ;
        default: begin
          st_nx    = S_IDLE;
          done_evt = 1'b1;
        end
      endcase
    end else begin
      case (st)
        S_ID_PREP:
          if (prep_cnt == PW'(PREP_CYCLES - 1)) begin
            st_nx    = S_ID_XFER;
            done_evt = 1'b1;
          end
        S_ID_XFER: if (data_rd && id_last) st_nx = S_IDLE;
        S_FL_REQ:  if (flush_ready) st_nx = S_FL_WAIT;
        S_FL_WAIT:
          if (flush_done) begin
            st_nx    = S_IDLE;
            done_evt = 1'b1;
          end
        S_DMA_REQ: if (dma_ready) st_nx = S_DMA_RUN;
        S_DMA_RUN:
          if (dma_done) begin
            st_nx    = S_IDLE;
            done_evt = 1'b1;
          end
        default: st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      prep_cnt <= '0;
      err_q    <= 1'b0;
      irq_q    <= 1'b0;
      dir_q    <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == S_ID_PREP) prep_cnt <= prep_cnt + 1'b1;
      else                 prep_cnt <= '0;
      if (cmd_ok) begin
        err_q <= !known;
        dir_q <= (cmd_op == OP_RDDMA);
      end
      if (done_evt)                irq_q <= 1'b1;
      else if (stat_rd || cmd_ok)  irq_q <= 1'b0;
    end
  end

  always_comb begin
    status          = 8'h00;
    status[ST_BSY]  = busy;
    status[ST_DRDY] = 1'b1;
    status[ST_DF]   = 1'b0;
    status[ST_DRQ]  = drq;
    status[ST_ERR]  = err_q;
  end

  assign err_reg     = {5'b0, err_q, 2'b0};
  assign irq         = irq_q;
  assign flush_valid = (st == S_FL_REQ);
  assign dma_valid   = (st == S_DMA_REQ);
  assign dma_dir     = dir_q;
endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter logic [15:0] BASE        = 16'h01F0,
  parameter int          LBA_BYTES   = 3,
  parameter int          ID_WORDS    = 256,
  parameter int          PREP_CYCLES = 4,
  parameter logic        DEV_ID      = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [15:0]            io_addr,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic [15:0]            io_wdata,
  output logic [15:0]            io_rdata,
  output logic                   irq,
  output logic                   flush_valid,
  input  logic                   flush_ready,
  input  logic                   flush_done,
  output logic                   dma_valid,
  input  logic                   dma_ready,
  output logic                   dma_dir,
  input  logic                   dma_done,
  output logic [8*LBA_BYTES-1:0] xfer_lba,
  output logic [7:0]             xfer_count
);
  logic        busy, drq, cmd_wr, stat_rd, data_rd, dev_sel;
  logic        id_start, id_adv, id_last;
  logic [7:0]  cmd_op, status_w, err_reg, dev_reg;
  logic [15:0] id_word_w;

  ata_tf_regs #(.BASE(BASE), .LBA_BYTES(LBA_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .busy(busy), .drq(drq), .status(status_w), .err_reg(err_reg),
    .data_word(id_word_w), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
    .stat_rd(stat_rd), .data_rd(data_rd), .dev_sel(dev_sel),
    .lba(xfer_lba), .count(xfer_count), .dev_reg(dev_reg)
  );

  ata_tf_idgen #(.WORDS(ID_WORDS)) u_idgen (
    .clk(clk), .rst_n(rst_n), .start(id_start), .advance(id_adv),
    .word(id_word_w), .last(id_last)
  );

  ata_tf_seq #(.PREP_CYCLES(PREP_CYCLES), .DEV_ID(DEV_ID)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
    .dev_sel(dev_sel), .stat_rd(stat_rd), .data_rd(data_rd),
    .id_last(id_last), .flush_ready(flush_ready), .flush_done(flush_done),
    .dma_ready(dma_ready), .dma_done(dma_done), .busy(busy), .drq(drq),
    .status(status_w), .err_reg(err_reg), .irq(irq),
    .id_start(id_start), .id_adv(id_adv), .flush_valid(flush_valid),
    .dma_valid(dma_valid), .dma_dir(dma_dir)
  );
endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk #(
  parameter int LBA_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             flush_valid,
  input logic             flush_ready,
  input logic             dma_valid,
  input logic             dma_ready,
  input logic             dma_dir,
  input logic [LBA_W-1:0] xfer_lba,
  input logic [7:0]       stat
);
  p_flush_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && !flush_ready |=> flush_valid);

  p_dma_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_valid && !dma_ready |=> dma_valid && $stable(dma_dir));

  p_one_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_valid && dma_valid));

  p_drq_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat[7] && stat[3]));

  p_busy_locks_lba_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stat[7]) && stat[7] |-> $stable(xfer_lba));

  p_req_means_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid || dma_valid) |-> stat[7]);
endmodule

bind ata_taskfile ata_taskfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .flush_valid(flush_valid),
  .flush_ready(flush_ready), .dma_valid(dma_valid), .dma_ready(dma_ready),
  .dma_dir(dma_dir), .xfer_lba(xfer_lba), .stat(status_w)
);

// File: tb/ata_taskfile_test.sv
`timescale 1ns/1ps
module ata_taskfile_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0, io_wdata = 16'h0, io_rdata;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic        irq, flush_valid, dma_valid, dma_dir;
  logic        flush_ready = 1'b0, flush_done = 1'b0, dma_ready = 1'b0, dma_done = 1'b0;
  logic [23:0] xfer_lba;
  logic [7:0]  xfer_count;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ata_taskfile uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .irq(irq),
    .flush_valid(flush_valid), .flush_ready(flush_ready), .flush_done(flush_done),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_dir(dma_dir),
    .dma_done(dma_done), .xfer_lba(xfer_lba), .xfer_count(xfer_count)
  );

  // {address, is_write, data or expected read byte}
  localparam int NV = 13;
  localparam logic [24:0] VEC [NV] = '{
    {16'h01F2, 1'b1, 8'h05}, {16'h01F3, 1'b1, 8'h12}, {16'h01F4, 1'b1, 8'h34},
    {16'h01F5, 1'b1, 8'h56}, {16'h01F6, 1'b1, 8'h40}, {16'h01FB, 1'b1, 8'h99},
    {16'h01F2, 1'b0, 8'h05}, {16'h01F3, 1'b0, 8'h12}, {16'h01F4, 1'b0, 8'h34},
    {16'h01F5, 1'b0, 8'h56}, {16'h01F6, 1'b0, 8'h40}, {16'h01FB, 1'b0, 8'h00},
    {16'h01E3, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    io_addr = a; io_rd = 1'b1;
    #2 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic wait_irq(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 50; i++) begin
      if (irq) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    bit ok;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 req", {flush_valid, dma_valid}, 0);
    rd(16'h01F7, d); chk("R1 status", d, 16'h0040);
    rd(16'h01F2, d); chk("R1 count", d, 0);
    rd(16'h01F6, d); chk("R1 device", d, 0);

    // R2 R3 register table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][8]) wr(VEC[i][24:9], {8'h00, VEC[i][7:0]});
      else begin
        rd(VEC[i][24:9], d);
        chk("R2/R3 table read", d, {8'h00, VEC[i][7:0]});
      end
    end
    chk("R3 lba", xfer_lba, 24'h563412);
    chk("R3 count", xfer_count, 8'h05);

    // R11 other device selected: command ignored
    wr(16'h01F6, 16'h0050);
    wr(16'h01F7, 16'h00E7);
    @(negedge clk);
    chk("R11 no request", {flush_valid, irq}, 0);
    rd(16'h01F7, d); chk("R11 status", d, 16'h0040);
    rd(16'h01F6, d); chk("R11 device readback", d, 16'h0050);
    wr(16'h01F6, 16'h0040);

    // R4 R5 identify
    wr(16'h01F7, 16'h00EC);
    rd(16'h01F7, d); chk("R4 busy during prep", d, 16'h00C0);
    wait_irq(ok); chk("R4 irq on ready", ok, 1);
    bad = 0;
    for (int i = 0; i < 256; i++) begin
      rd(16'h01F7, d);
      if (d !== 16'h0048) bad++;
      rd(16'h01F0, d);
      if (d !== ((i == 85) ? 16'h0020 : {8'hA5, 8'(i)})) bad++;
    end
    chk("R4/R5 identify words and status", bad, 0);
    chk("R8 irq cleared by status read", irq, 0);
    rd(16'h01F7, d); chk("R4 status after last word", d, 16'h0040);
    rd(16'h01F6, d); chk("R11 DEV bit 0", d[4], 0);

    // R6 R9 flush with busy-time writes
    wr(16'h01F7, 16'h00E7);
    repeat (2) @(negedge clk);
    chk("R6 flush_valid held", flush_valid, 1);
    rd(16'h01F7, d); chk("R6 status pending", d, 16'h00C0);
    wr(16'h01F3, 16'h0077);
    wr(16'h01F7, 16'h00C8);
    flush_ready = 1'b1; @(negedge clk); flush_ready = 1'b0;
    chk("R9 no dma from busy command", {flush_valid, dma_valid}, 0);
    repeat (3) @(negedge clk);
    rd(16'h01F7, d); chk("R6 status awaiting done", d, 16'h00C0);
    chk("R6 no irq before done", irq, 0);
    flush_done = 1'b1; @(negedge clk); flush_done = 1'b0;
    chk("R6 irq at done", irq, 1);
    rd(16'h01F7, d); chk("R6 status done", d, 16'h0040);
    chk("R8 irq cleared", irq, 0);
    rd(16'h01F3, d); chk("R9 lba write ignored", d, 16'h0012);

    // R7 DMA both directions
    wr(16'h01F7, 16'h00C8);
    chk("R7 read dma", {dma_valid, dma_dir}, 2'b11);
    chk("R7 lba handoff", xfer_lba, 24'h563412);
    dma_ready = 1'b1; @(negedge clk); dma_ready = 1'b0;
    chk("R7 valid drops", dma_valid, 0);
    rd(16'h01F7, d); chk("R7 busy", d, 16'h00C0);
    dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
    chk("R7 irq", irq, 1);
    rd(16'h01F7, d); chk("R7 status done", d, 16'h0040);
    wr(16'h01F7, 16'h00CA);
    chk("R7 write dma", {dma_valid, dma_dir}, 2'b10);
    dma_ready = 1'b1; @(negedge clk); dma_ready = 1'b0;
    dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
    chk("R7 irq write", irq, 1);
    rd(16'h01F7, d);

    // R10 unsupported opcode
    wr(16'h01F7, 16'h0055);
    chk("R10 irq", irq, 1);
    rd(16'h01F7, d); chk("R10 status", d, 16'h0041);
    rd(16'h01F1, d); chk("R10 error reg", d, 16'h0004);
    wr(16'h01F7, 16'h00E7);
    rd(16'h01F7, d); chk("R10 error cleared", d, 16'h00C0);
    rd(16'h01F1, d); chk("R10 error reg cleared", d, 16'h0000);
    flush_ready = 1'b1; @(negedge clk); flush_ready = 1'b0;
    flush_done = 1'b1; @(negedge clk); flush_done = 1'b0;
    rd(16'h01F7, d); chk("R6 second flush done", d, 16'h0040);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule